// File: doc/BRIEF.md
# Banked Register File with Bit Addressing

This block is a 128-byte internal data store for a small controller core. It has three address regions. The lowest 32 bytes hold four banks of eight working registers. Bytes 20h to 2Fh can be reached either as whole bytes or as 128 single bits. Bytes 30h to 7Fh are plain scratch storage. One operation is accepted per clock. It is selected by a 3-bit operation code and uses a shared 8-bit address, a 2-bit bank selector and a write byte.

Register operations take a register number from 0 to 7. The block adds it to eight times the bank selector, so the core can switch register context with a single field. Bit operations set, clear, invert or test one bit in the bit region. They do this as a read-modify-write of the byte that holds the bit, completed in the same cycle, and every other bit of that byte is kept. All results are registered. A byte or bit address of 80h or more raises an error pulse instead of touching memory.

Top module: `iram_bank_bit`

## Requirements
- R1: Reset clears all 128 bytes to 00h and drives rd_valid, bit_valid and addr_err low.
- R2: Opcode 0 reads byte `addr` (below 80h): rd_data carries it and rd_valid is high in the cycle after acceptance. Opcode 1 writes wr_data to byte `addr`, and any operation accepted in a later cycle sees the new value.
- R3: Opcode 2 reads and opcode 3 writes physical byte bank_sel*8 + addr[2:0]. addr[7:3] has no effect on these operations.
- R4: A bit address n below 80h selects byte 20h + n[6:3], bit position n[2:0]. Bytes 20h to 2Fh are also readable and writable as bytes.
- R5: Opcodes 4, 5 and 6 make the selected bit 1, 0 or its inverse, in one operation. The other seven bits of the byte are unchanged.
- R6: Opcode 7 returns the selected bit on bit_val with bit_valid high and changes no memory. Every bit opcode (4 to 7) returns the bit's value from before the operation.
- R7: A byte opcode (0 or 1) or bit opcode (4 to 7) with addr of 80h or above gives addr_err high for one cycle. No byte is written, and rd_valid and bit_valid stay low.
- R8: Register opcodes (2 and 3) never raise addr_err, whatever addr[7:3] and bank_sel hold.
- R9: When op_valid is low, no byte changes and rd_valid, bit_valid and addr_err are low in the next cycle.
- R10: A new operation can be accepted every cycle. At most one of rd_valid, bit_valid and addr_err is high in a cycle, and each pulses once per accepted operation, including a bit operation that follows another on the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | 0 byte read, 1 byte write, 2 register read, 3 register write, 4 bit set, 5 bit clear, 6 bit invert, 7 bit test |
| addr | input | 8 | Byte address, register number (bits 2:0) or bit address |
| bank_sel | input | 2 | Active register bank |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read result, 00h when rd_valid is low |
| rd_valid | output | 1 | rd_data holds a read result |
| bit_val | output | 1 | Prior value of the addressed bit |
| bit_valid | output | 1 | bit_val holds a bit result |
| addr_err | output | 1 | Previous operation addressed 80h or above |

## Verification
Every result (read byte, bit value or error pulse) appears exactly one rising edge after the operation is accepted. A write becomes visible to an operation accepted on the very next edge. The bench stamps each expectation with the cycle count at which it drove the operation. The monitor compares only expectations whose stamp is older than the current count, sampling at the falling edge, so each comparison lands in the single cycle where the result is due. Idle cycles push expectations of all-quiet outputs, which pins down that the valids pulse for one cycle only. A final sweep reads all 128 bytes to show that ignored writes left no trace.

// File: rtl/iram_pkg.sv
package iram_pkg;

  typedef enum logic [2:0] {
    OP_BRD  = 3'd0,
    OP_BWR  = 3'd1,
    OP_RRD  = 3'd2,
    OP_RWR  = 3'd3,
    OP_BSET = 3'd4,
    OP_BCLR = 3'd5,
    OP_BCPL = 3'd6,
    OP_BTST = 3'd7
  } iram_op_e;

  // Physical byte index of working register rn in bank `bank`.
  function automatic int reg_index(int bank, int rn, int regs);
    return bank * regs + rn;
  endfunction

  // Byte that holds bit address baddr.
  function automatic int bit_byte_index(int baddr, int base, int w);
    return base + baddr / w;
  endfunction

  // Position of bit address baddr inside its byte.
  function automatic int bit_offset(int baddr, int w);
    return baddr % w;
  endfunction

  function automatic logic is_bit_op(iram_op_e op);
    return op inside {OP_BSET, OP_BCLR, OP_BCPL, OP_BTST};
  endfunction

  function automatic logic is_byte_op(iram_op_e op);
    return op inside {OP_BRD, OP_BWR};
  endfunction

endpackage

// File: rtl/iram_decode.sv
module iram_decode
  import iram_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int W         = 8,
  parameter int BANKS     = 4,
  parameter int REGS      = 8,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  parameter int ADDR_W    = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int PW  = $clog2(W),
  localparam int BSW = $clog2(BANKS)
) (
  input  logic              op_valid,
  input  iram_op_e          op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BSW-1:0]    bank,
  output logic [AW-1:0]     idx,
  output logic [PW-1:0]     pos,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              bit_fire,
  output logic              bit_wr,
  output logic              err_fire
);

  localparam int BIT_SPAN = BIT_BYTES * W;

  logic err;
  int   a_int;

  always_comb begin
    a_int = int'(addr);
    err   = 1'b0;
    idx   = '0;
    pos   = '0;
    if (is_byte_op(op)) begin
      err = (a_int >= DEPTH);
      idx = AW'(a_int);
    end else if (is_bit_op(op)) begin
      err = (a_int >= BIT_SPAN);
      idx = AW'(bit_byte_index(a_int, BIT_BASE, W));
      pos = PW'(bit_offset(a_int, W));
    end else begin
      idx = AW'(reg_index(int'(bank), a_int % REGS, REGS));
    end
  end

  always_comb begin
    rd_fire  = op_valid && !err && (op == OP_BRD || op == OP_RRD);
    wr_fire  = op_valid && !err && (op == OP_BWR || op == OP_RWR);
    bit_fire = op_valid && !err && is_bit_op(op);
    bit_wr   = bit_fire && (op != OP_BTST);
    err_fire = op_valid && err;
  end

endmodule

// File: rtl/iram_bitmerge.sv
module iram_bitmerge
  import iram_pkg::*;
#(
  parameter int W = 8,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  old_byte,
  input  logic [PW-1:0] pos,
  input  iram_op_e      op,
  output logic [W-1:0]  new_byte,
  output logic          old_bit
);

  logic [W-1:0] mask;

  always_comb begin
    mask    = W'(1) << pos;
    old_bit = old_byte[pos];
    case (op)
      OP_BSET: new_byte = old_byte | mask;
      OP_BCLR: new_byte = old_byte & ~mask;
      OP_BCPL: new_byte = old_byte ^ mask;
      default: new_byte = old_byte;
    endcase
  end

endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/iram_bank_bit.sv
module iram_bank_bit
  import iram_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int W         = 8,
  parameter int BANKS     = 4,
  parameter int REGS      = 8,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int OP_W      = 3,
  localparam int BSW = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BSW-1:0]    bank_sel,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic              rd_valid,
  output logic              bit_val,
  output logic              bit_valid,
  output logic              addr_err
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(W);

  iram_op_e      op;
  logic [AW-1:0] idx;
  logic [PW-1:0] bit_pos;
  logic          rd_fire, wr_fire, bit_fire, bit_wr, err_fire;
  logic [W-1:0]  old_byte, new_byte;
  logic          old_bit;
  logic          st_we;
  logic [W-1:0]  st_wdata;

  assign op = iram_op_e'(op_code);

  iram_decode #(
    .DEPTH(DEPTH), .W(W), .BANKS(BANKS), .REGS(REGS),
    .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES), .ADDR_W(ADDR_W)
  ) u_dec (
    .op_valid (op_valid),
    .op       (op),
    .addr     (addr),
    .bank     (bank_sel),
    .idx      (idx),
    .pos      (bit_pos),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .bit_fire (bit_fire),
    .bit_wr   (bit_wr),
    .err_fire (err_fire)
  );

  iram_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .idx   (idx),
    .wdata (st_wdata),
    .rdata (old_byte)
  );

  iram_bitmerge #(.W(W)) u_merge (
    .old_byte (old_byte),
    .pos      (bit_pos),
    .op       (op),
    .new_byte (new_byte),
    .old_bit  (old_bit)
  );

  assign st_we    = wr_fire || bit_wr;
  assign st_wdata = bit_wr ? new_byte : wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      bit_val   <= 1'b0;
      bit_valid <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      rd_data   <= rd_fire ? old_byte : '0;
      rd_valid  <= rd_fire;
      bit_val   <= bit_fire && old_bit;
      bit_valid <= bit_fire;
      addr_err  <= err_fire;
    end
  end

endmodule

// File: rtl/iram_bank_bit_chk.sv
module iram_bank_bit_chk #(
  parameter int DEPTH  = 128,
  parameter int W      = 8,
  parameter int ADDR_W = 8,
  parameter int OP_W   = 3,
  localparam int PW = $clog2(W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic              bit_valid,
  input logic              addr_err,
  input logic              st_we,
  input logic              err_fire,
  input logic              bit_wr,
  input logic [W-1:0]      old_byte,
  input logic [W-1:0]      new_byte,
  input logic [PW-1:0]     bit_pos
);

  // R7
  byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[2:1] == 2'b00 && int'(addr) >= DEPTH) |=> (addr_err && !rd_valid));

  // R7
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |-> !st_we);

  // R6
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd7) |-> !st_we);

  // R5
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |-> (((old_byte ^ new_byte) & ~(W'(1) << bit_pos)) == '0));

  // R5
  merge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && op_code == 3'd4) |-> new_byte[bit_pos]);

  // R8
  reg_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[2:1] == 2'b01) |=> !addr_err);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!rd_valid && !bit_valid && !addr_err));

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !st_we);

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, bit_valid, addr_err}));

endmodule

bind iram_bank_bit iram_bank_bit_chk #(
  .DEPTH(DEPTH), .W(W), .ADDR_W(ADDR_W), .OP_W(OP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .addr      (addr),
  .rd_valid  (rd_valid),
  .bit_valid (bit_valid),
  .addr_err  (addr_err),
  .st_we     (st_we),
  .err_fire  (err_fire),
  .bit_wr    (bit_wr),
  .old_byte  (old_byte),
  .new_byte  (new_byte),
  .bit_pos   (bit_pos)
);

// File: tb/tb_iram_bank_bit.sv
`timescale 1ns/1ps
module tb_iram_bank_bit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] addr = 8'd0;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       rd_valid, bit_val, bit_valid, addr_err;

  always #5 clk = ~clk;

  iram_bank_bit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .addr(addr), .bank_sel(bank_sel), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .bit_val(bit_val),
    .bit_valid(bit_valid), .addr_err(addr_err)
  );

  typedef struct {
    int         stamp;
    int         kind;   // 0 quiet, 1 byte read, 2 bit result, 3 error
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t       q[$];
  logic [7:0] ref_mem [128];
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int kind, logic [7:0] val, string req);
    exp_t e;
    e.stamp = cyc; e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // Driver: one operation per call, expectation from the reference model.
  task automatic drive(int op, int a, int bank, logic [7:0] wd, string req);
    int b, p;
    logic old;
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'(op); addr = 8'(a);
    bank_sel = 2'(bank); wr_data = wd;
    case (op)
      0: if (a >= 128) push(3, 8'h00, req); else push(1, ref_mem[a], req);
      1: if (a >= 128) push(3, 8'h00, req);
         else begin ref_mem[a] = wd; push(0, 8'h00, req); end
      2: push(1, ref_mem[bank * 8 + a % 8], req);
      3: begin ref_mem[bank * 8 + a % 8] = wd; push(0, 8'h00, req); end
      default: begin
        if (a >= 128) push(3, 8'h00, req);
        else begin
          b = 32 + a / 8; p = a % 8;
          old = ref_mem[b][p];
          if (op == 4) ref_mem[b][p] = 1'b1;
          if (op == 5) ref_mem[b][p] = 1'b0;
          if (op == 6) ref_mem[b][p] = ~old;
          push(2, {7'd0, old}, req);
        end
      end
    endcase
  endtask

  // Idle cycle with junk on the other inputs.
  task automatic idle(string req);
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd1; addr = 8'h10; wr_data = 8'hEE;
    push(0, 8'h00, req);
  endtask

  // Monitor: compares results due one edge after each driven operation.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      bit ok;
      e = q.pop_front();
      case (e.kind)
        0: ok = !rd_valid && !bit_valid && !addr_err;
        1: ok = rd_valid && !bit_valid && !addr_err && rd_data == e.val;
        2: ok = bit_valid && !rd_valid && !addr_err && bit_val == e.val[0];
        default: ok = addr_err && !rd_valid && !bit_valid;
      endcase
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s: actual rv=%0b rd=%02h bv=%0b bval=%0b err=%0b expected kind=%0d val=%02h",
                 e.req, rd_valid, rd_data, bit_valid, bit_val, addr_err, e.kind, e.val);
      end
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_valid || bit_valid || addr_err) begin
      errors++;
      $display("FAIL R1: actual rv=%0b bv=%0b err=%0b expected 0 0 0", rd_valid, bit_valid, addr_err);
    end
    rst_n = 1'b1;

    // R1: memory cleared
    drive(0, 8'h00, 0, 8'h00, "R1");
    drive(0, 8'h25, 0, 8'h00, "R1");
    drive(0, 8'h7F, 0, 8'h00, "R1");

    // R2: fill every byte, read a spread back
    for (int i = 0; i < 128; i++) drive(1, i, 0, 8'((i * 37 + 5) & 8'hFF), "R2");
    for (int i = 0; i < 128; i += 9) drive(0, i, 0, 8'h00, "R2");

    // R10: write then read same byte on the next cycle
    drive(1, 8'h40, 0, 8'hA5, "R10");
    drive(0, 8'h40, 0, 8'h00, "R10");
    drive(1, 8'h40, 0, 8'h5A, "R10");
    drive(0, 8'h40, 0, 8'h00, "R10");

    // R3 / R8: register mapping through bank select, upper addr bits junk
    for (int bk = 0; bk < 4; bk++) drive(3, 8'hF8 | (bk + 2), bk, 8'(8'hC0 + bk), "R3");
    for (int bk = 0; bk < 4; bk++) drive(2, 8'hA8 | (bk + 2), bk, 8'h00, "R8");
    for (int bk = 0; bk < 4; bk++) drive(0, bk * 8 + bk + 2, 0, 8'h00, "R3");
    drive(3, 8'h07, 3, 8'h3C, "R3");
    drive(0, 8'h1F, 0, 8'h00, "R3");

    // R4 / R5 / R6: bit operations
    drive(1, 8'h20, 0, 8'h00, "R4");
    drive(1, 8'h2F, 0, 8'hFF, "R4");
    drive(4, 0, 0, 8'h00, "R5");
    drive(4, 7, 0, 8'h00, "R5");
    drive(6, 3, 0, 8'h00, "R5");
    drive(5, 127, 0, 8'h00, "R5");
    drive(7, 127, 0, 8'h00, "R6");
    drive(7, 0, 0, 8'h00, "R6");
    drive(6, 0, 0, 8'h00, "R6");
    drive(0, 8'h20, 0, 8'h00, "R4");
    drive(0, 8'h2F, 0, 8'h00, "R4");
    drive(5, 8'h45, 0, 8'h00, "R5");
    drive(7, 8'h45, 0, 8'h00, "R6");
    drive(0, 8'h28, 0, 8'h00, "R4");
    drive(1, 8'h21, 0, 8'h00, "R10");
    drive(4, 8, 0, 8'h00, "R10");
    drive(4, 9, 0, 8'h00, "R10");
    drive(6, 15, 0, 8'h00, "R10");
    drive(0, 8'h21, 0, 8'h00, "R10");

    // R7: out-of-range byte and bit addresses
    drive(1, 8'h80, 0, 8'h11, "R7");
    drive(0, 8'hFF, 0, 8'h00, "R7");
    drive(4, 8'h80, 0, 8'h00, "R7");
    drive(7, 8'hC3, 0, 8'h00, "R7");
    drive(1, 8'hFF, 0, 8'h22, "R7");
    drive(0, 8'h00, 0, 8'h00, "R7");

    // R9: idle with junk inputs
    for (int i = 0; i < 4; i++) idle("R9");
    drive(0, 8'h10, 0, 8'h00, "R9");

    // R2 / R7 / R9: full sweep against the model
    for (int i = 0; i < 128; i++) drive(0, i, 0, 8'h00, "R2");
    idle("R9");
    idle("R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10: watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule